// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a single-word request port inside a synchronous design and an external asynchronous static RAM of 524,288 bytes. Each request is accepted only while the block is idle. The block then runs one read or one write on the memory pins, using active-low chip-select, output-enable and write-strobe signals. Every phase lasts a whole number of system clock cycles, and those counts are derived from the memory's access time and its bus-release time.

Between accesses the memory is kept deselected, so it can fall into its low-power state and stop driving the data lines. The bidirectional data bus is given as three plain ports: the value the controller drives, a drive-enable, and the value sampled from the pins. Read data is registered at the end of the read phase. A one-cycle completion pulse then marks the result as valid.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, and whenever chip-select is high, output-enable and write-strobe are both high and the data drive-enable is low. The completion pulse is low after reset.
- R2: With no request pending, chip-select stays high (memory deselected) on every cycle.
- R3: A read holds chip-select low, output-enable low, write-strobe high and drive-enable low for exactly RD_LEN consecutive cycles, where RD_LEN = ceil(ACCESS_NS / CLK_PERIOD_NS) + 1.
- R4: Read data is sampled from the data input on the last read-phase cycle and appears on the read-data port when the completion pulse is high. It then holds its value through later writes until the next read completes.
- R5: A write holds chip-select low, write-strobe low and output-enable high for exactly WR_LEN = max(1, ceil(ACCESS_NS / CLK_PERIOD_NS)) consecutive cycles. The data drive-enable is high during those cycles and at no other time, and the driven value equals the request's write data.
- R6: The memory address equals the accepted request address and does not change while chip-select is low.
- R7: Each accepted request yields exactly one completion pulse, one cycle wide, in the cycle right after its last access cycle.
- R8: After every access, chip-select stays high for at least REC_LEN + 1 cycles before the next access, where REC_LEN = max(1, ceil(RELEASE_NS / CLK_PERIOD_NS)). A request strobe raised during an access or its recovery is ignored: it causes no extra completion and no address change.
- R9: The controller's data drive-enable is never high while output-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Last read result |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_ce_n | output | 1 | Memory chip-select, active low |
| mem_oe_n | output | 1 | Memory output-enable, active low |
| mem_we_n | output | 1 | Memory write-strobe, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive-enable for the data bus |
| mem_dq_in | input | DATA_W | Data sampled from the memory bus |

## Verification
A phase counter that is off by one shows up at once as a read or write phase of the wrong length. It also shows up as a completion pulse one cycle early or late, and for reads as data sampled from the floating-bus value rather than from the memory. A stuck or misdecoded phase register drives a strobe pattern the memory does not accept, such as drive-enable high together with output-enable low. It can also make chip-select fall too soon after the previous access, and both faults appear on the pins within the same access. A capture register that loads at the wrong time is seen at the next completion, as read data that disagrees with the value written to that address in the sweep.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2,
        PH_RECOV = 2'd3
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Pin pattern for each phase of the access sequence.
    function automatic strobe_t strobes_for(input phase_e ph);
        strobe_t s;
        case (ph)
            PH_READ:  s = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
            PH_WRITE: s = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
            default:  s = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_access_seq.sv
module sram_access_seq
    import sram_seq_pkg::*;
#(
    parameter int unsigned RD_LEN  = 4,
    parameter int unsigned WR_LEN  = 3,
    parameter int unsigned REC_LEN = 1,
    parameter int unsigned CNT_W   = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   req_write,
    output logic   accept,
    output logic   capture,
    output logic   done,
    output phase_e phase
);
    localparam logic [CNT_W-1:0] RD_M1  = CNT_W'(RD_LEN - 1);
    localparam logic [CNT_W-1:0] WR_M1  = CNT_W'(WR_LEN - 1);
    localparam logic [CNT_W-1:0] REC_M1 = CNT_W'(REC_LEN - 1);

    phase_e           phase_q, phase_d;
    logic             t_load, t_last, end_acc, done_q;
    logic [CNT_W-1:0] t_val;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    always_comb begin
        phase_d = phase_q;
        t_load  = 1'b0;
        t_val   = '0;
        accept  = 1'b0;
        capture = 1'b0;
        end_acc = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    t_load  = 1'b1;
                    phase_d = req_write ? PH_WRITE : PH_READ;
                    t_val   = req_write ? WR_M1 : RD_M1;
                end
            end
            PH_READ: begin
                if (t_last) begin
                    capture = 1'b1;
                    end_acc = 1'b1;
                    t_load  = 1'b1;
                    t_val   = REC_M1;
                    phase_d = PH_RECOV;
                end
            end
            PH_WRITE: begin
                if (t_last) begin
                    end_acc = 1'b1;
                    t_load  = 1'b1;
                    t_val   = REC_M1;
                    phase_d = PH_RECOV;
                end
            end
            default: begin
                if (t_last) begin
                    phase_d = PH_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done_q  <= end_acc;
        end
    end

    assign phase = phase_q;
    assign done  = done_q;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_in_recov_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (phase_q == PH_RECOV));

endmodule

// File: rtl/sram_bus_regs.sv
module sram_bus_regs #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= dq_in;
        end
    end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int unsigned ADDR_W        = 19,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned ACCESS_NS     = 25,
    parameter int unsigned RELEASE_NS    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned ACC_CYC = ceil_div(ACCESS_NS, CLK_PERIOD_NS);
    localparam int unsigned RD_LEN  = ACC_CYC + 1;
    localparam int unsigned WR_LEN  = at_least_one(ACC_CYC);
    localparam int unsigned REC_LEN = at_least_one(ceil_div(RELEASE_NS, CLK_PERIOD_NS));
    localparam int unsigned CNT_W   = $clog2(max3(RD_LEN, WR_LEN, REC_LEN) + 1);

    logic    accept, capture;
    phase_e  phase;
    strobe_t pins;

    sram_access_seq #(
        .RD_LEN  (RD_LEN),
        .WR_LEN  (WR_LEN),
        .REC_LEN (REC_LEN),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .accept    (accept),
        .capture   (capture),
        .done      (rsp_done),
        .phase     (phase)
    );

    sram_bus_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (mem_dq_in),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out),
        .rdata_q   (rsp_rdata)
    );

    assign pins      = strobes_for(phase);
    assign mem_ce_n  = pins.ce_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_dq_oe = pins.drive;

    // R9
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_dq_oe && !mem_oe_n));

    // R1
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mem_ce_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    // R8
    release_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_ce_n) |=> mem_ce_n);

    // R7
    done_after_access_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (mem_ce_n && !$past(mem_ce_n)));

endmodule

// File: tb/sram_seq_ctrl_bench.sv
module sram_seq_ctrl_bench;
    localparam int PERIOD  = 8;
    localparam int ACC_NS  = 25;
    localparam int REL_NS  = 10;
    localparam int AW      = 6;
    localparam int DW      = 8;
    localparam int WORDS   = 1 << AW;
    localparam int EXP_RD  = (ACC_NS + PERIOD - 1) / PERIOD + 1;
    localparam int EXP_WR  = (ACC_NS + PERIOD - 1) / PERIOD;
    localparam int EXP_REC = (REL_NS + PERIOD - 1) / PERIOD;
    localparam logic [DW-1:0] FLOAT_VAL = 8'hA5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_done;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    int tests = 0;
    int fails = 0;
    int overlap = 0;
    int gap_bad = 0;
    int hi_run = 0;
    bit seen_low = 0;
    logic [DW-1:0] last_rd = '0;
    logic [DW-1:0] ram [WORDS];

    always #(PERIOD/2) clk = ~clk;

    sram_seq_ctrl #(
        .ADDR_W        (AW),
        .DATA_W        (DW),
        .CLK_PERIOD_NS (PERIOD),
        .ACCESS_NS     (ACC_NS),
        .RELEASE_NS    (REL_NS)
    ) u_sram_seq_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_rdata  (rsp_rdata),
        .rsp_done   (rsp_done),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    // Memory model: accepts a write while selected and strobed, drives only in read mode.
    always @(posedge clk)
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) ram[mem_addr] <= mem_dq_out;
    assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? ram[mem_addr] : FLOAT_VAL;

    // Pin monitor for R8 (deselect gap) and R9 (no overlap).
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_dq_oe && !mem_oe_n) overlap++;
            if (mem_ce_n) begin
                hi_run++;
            end else begin
                if (seen_low && hi_run != 0 && hi_run < EXP_REC + 1) gap_bad++;
                hi_run = 0;
                seen_low = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat_a(input int a);
        return DW'((a * 37 + 5) & 8'hFF);
    endfunction

    function automatic logic [DW-1:0] pat_b(input int a);
        return DW'((a * 91 + 200) & 8'hFF);
    endfunction

    task automatic access(input bit wr, input int a, input logic [DW-1:0] d, input bit poke);
        int  cyc;
        bit  good, addr_ok, early;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(a);
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0; good = 1; addr_ok = 1; early = 0;
        for (int i = 0; i < 40; i++) begin
            if (rsp_done) break;
            if (wr)
                good &= (!mem_ce_n && !mem_we_n && mem_oe_n && mem_dq_oe && mem_dq_out == d);
            else
                good &= (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe);
            if (mem_ce_n) early = 1;
            addr_ok &= (mem_addr == AW'(a));
            cyc++;
            if (poke) begin
                req_valid = (cyc == 2);
                req_write = ~wr;
                req_addr  = ~AW'(a);
                req_wdata = ~d;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (wr) begin
            // R5: write phase length, pattern and driven value
            chk(good && cyc == EXP_WR && !early, "R5", cyc, EXP_WR);
            // R4: read result held across writes
            chk(rsp_rdata == last_rd, "R4", rsp_rdata, last_rd);
        end else begin
            // R3: read phase length and pattern
            chk(good && cyc == EXP_RD && !early, "R3", cyc, EXP_RD);
            // R4: captured data at completion
            chk(rsp_rdata == d, "R4", rsp_rdata, d);
            last_rd = rsp_rdata;
        end
        // R6: address tracks request and stays stable
        chk(addr_ok && rsp_done, "R6", mem_addr, a);
        @(negedge clk);
        // R7: pulse is one cycle wide
        chk(!rsp_done, "R7", rsp_done, 0);
        if (poke) begin
            good = 1;
            for (int i = 0; i < EXP_REC + 2; i++) begin
                good &= (!rsp_done && mem_ce_n && mem_addr == AW'(a));
                @(negedge clk);
            end
            // R8: strobe during access ignored
            chk(good, "R8", mem_addr, a);
        end
    endtask

    initial begin
        bit idle_ok;
        repeat (3) @(negedge clk);
        // R1: pins during reset
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_done, "R1",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_done}, 5'b11100);
        rst = 1'b0;
        @(negedge clk);
        // R1: pins after reset release
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_done, "R1",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_done}, 5'b11100);

        for (int a = 0; a < WORDS; a++) access(1'b1, a, pat_a(a), (a % 5) == 0);
        for (int a = 0; a < WORDS; a++) access(1'b0, a, pat_a(a), (a % 7) == 3);
        for (int a = 0; a < WORDS; a += 3) begin
            access(1'b1, a, pat_b(a), 1'b0);
            access(1'b0, a, pat_b(a), 1'b0);
        end

        idle_ok = 1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            idle_ok &= (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_done);
        end
        // R2: deselected while idle
        chk(idle_ok, "R2", mem_ce_n, 1);
        // R9: no drive while memory outputs enabled
        chk(overlap == 0, "R9", overlap, 0);
        // R8: minimum deselect gap between accesses
        chk(gap_bad == 0, "R8", gap_bad, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule